// File: doc/BRIEF.md
# Doubleword Shift Unit with Word Forms

This block performs every shift a 64-bit integer datapath needs from one shared barrel shifter. An opcode picks the direction and fill: left, logical right (zero fill) or arithmetic right (sign fill). It also picks where the shift amount comes from: a 5-bit immediate field, or the low bits of a 64-bit amount register.

Word forms work on the low 32 bits of the operand only. Their 32-bit result is sign-extended into all 64 output bits. Doubleword forms shift the full 64-bit operand. The "high" doubleword forms add 32 to the 5-bit immediate, so amounts 32 to 63 are reachable without a register.

The result is registered once, so it appears on the output one clock after the inputs are presented. The datapath places the unit between operand fetch and write-back.

Top module: `shf_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `result` is zero.
- R2: Opcodes 0 (immediate) and 3 (variable) shift the low 32 bits of `operand` left. The 32-bit result is sign-extended from its bit 31 to 64 bits.
- R3: Opcodes 1 (immediate) and 4 (variable) shift the low 32 bits right as an unsigned value. The 32-bit result is sign-extended. A shift by zero therefore copies operand bit 31 into result bits 63..32.
- R4: Opcodes 2 (immediate) and 5 (variable) shift the low 32 bits right as a signed value. The result is sign-extended to 64 bits.
- R5: Word variable forms (opcodes 3, 4, 5) use only bits 4..0 of `amt_reg`. All higher bits have no effect.
- R6: Opcodes 6 (left), 7 (logical right) and 8 (arithmetic right) shift all 64 bits by `shamt` (0 to 31).
- R7: Opcodes 9 (left), 10 (logical right) and 11 (arithmetic right) shift all 64 bits by `amt_reg[5:0]`. Bits 63..6 of `amt_reg` have no effect.
- R8: Opcodes 12 (left), 13 (logical right) and 14 (arithmetic right) shift all 64 bits by 32 + `shamt`, an amount from 32 to 63.
- R9: Opcode 15 is unused and gives a zero result.
- R10: Each result is registered. It appears on `result` at the first rising clock edge after its inputs are applied, and it holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code (see requirements) |
| shamt | input | 5 | Immediate shift amount field |
| amt_reg | input | 64 | Register value supplying variable shift amounts |
| operand | input | 64 | Value to be shifted |
| result | output | 64 | Registered shift result |

## Verification
All results are due exactly one rising edge after their inputs. The bench drives inputs on a falling edge and samples on the next falling edge, so exactly one register stage lies between stimulus and check. A back-to-back pair of operations confirms that each result appears in its own cycle and is not delayed by a second cycle. The bound checker compares its property consequents against inputs captured with `$past` one cycle back, which matches the same single-stage latency.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [3:0] {
        OP_WL_I = 4'd0,  OP_WR_I = 4'd1,  OP_WA_I = 4'd2,
        OP_WL_V = 4'd3,  OP_WR_V = 4'd4,  OP_WA_V = 4'd5,
        OP_DL_I = 4'd6,  OP_DR_I = 4'd7,  OP_DA_I = 4'd8,
        OP_DL_V = 4'd9,  OP_DR_V = 4'd10, OP_DA_V = 4'd11,
        OP_DL_H = 4'd12, OP_DR_H = 4'd13, OP_DA_H = 4'd14,
        OP_NONE = 4'd15
    } shf_op_e;

    typedef enum logic [1:0] {
        K_LEFT  = 2'd0,
        K_LOGIC = 2'd1,
        K_ARITH = 2'd2
    } shf_kind_e;

    typedef enum logic [2:0] {
        F_WIMM = 3'd0,
        F_WVAR = 3'd1,
        F_DIMM = 3'd2,
        F_DVAR = 3'd3,
        F_DHI  = 3'd4,
        F_NONE = 3'd5
    } shf_form_e;

    function automatic shf_form_e op_form(input shf_op_e op);
        case (op)
            OP_WL_I, OP_WR_I, OP_WA_I: op_form = F_WIMM;
            OP_WL_V, OP_WR_V, OP_WA_V: op_form = F_WVAR;
            OP_DL_I, OP_DR_I, OP_DA_I: op_form = F_DIMM;
            OP_DL_V, OP_DR_V, OP_DA_V: op_form = F_DVAR;
            OP_DL_H, OP_DR_H, OP_DA_H: op_form = F_DHI;
            default:                   op_form = F_NONE;
        endcase
    endfunction

    function automatic shf_kind_e op_kind(input shf_op_e op);
        case (op)
            OP_WL_I, OP_WL_V, OP_DL_I, OP_DL_V, OP_DL_H: op_kind = K_LEFT;
            OP_WR_I, OP_WR_V, OP_DR_I, OP_DR_V, OP_DR_H: op_kind = K_LOGIC;
            default:                                      op_kind = K_ARITH;
        endcase
    endfunction

endpackage

// File: rtl/shf_amt_sel.sv
module shf_amt_sel
    import shf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32,
    localparam int AMT_W = $clog2(DATA_W),
    localparam int IMM_W = $clog2(WORD_W)
) (
    input  shf_op_e            op,
    input  logic [IMM_W-1:0]   imm,
    input  logic [DATA_W-1:0]  amt_reg,
    output logic [AMT_W-1:0]   amt,
    output shf_kind_e          kind,
    output logic               is_word,
    output logic               is_valid
);

    shf_form_e form;

    always_comb begin
        form     = op_form(op);
        kind     = op_kind(op);
        is_word  = (form == F_WIMM) || (form == F_WVAR);
        is_valid = (form != F_NONE);
        case (form)
            F_WIMM, F_DIMM: amt = AMT_W'(imm);
            F_WVAR:         amt = AMT_W'(amt_reg[IMM_W-1:0]);
            F_DVAR:         amt = amt_reg[AMT_W-1:0];
            F_DHI:          amt = AMT_W'(WORD_W) | AMT_W'(imm);
            default:        amt = '0;
        endcase
    end

endmodule

// File: rtl/shf_word_adapt.sv
module shf_word_adapt
    import shf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] operand,
    input  shf_kind_e         kind,
    input  logic              is_word,
    input  logic [DATA_W-1:0] shifted,
    output logic [DATA_W-1:0] core_in,
    output logic [DATA_W-1:0] final_out
);

    logic [WORD_W-1:0] low_in;
    logic [WORD_W-1:0] low_out;

    always_comb begin
        low_in  = operand[WORD_W-1:0];
        low_out = shifted[WORD_W-1:0];
        if (!is_word) begin
            core_in = operand;
        end else if (kind == K_ARITH) begin
            core_in = {{(DATA_W-WORD_W){low_in[WORD_W-1]}}, low_in};
        end else begin
            core_in = {{(DATA_W-WORD_W){1'b0}}, low_in};
        end
        if (is_word) begin
            final_out = {{(DATA_W-WORD_W){low_out[WORD_W-1]}}, low_out};
        end else begin
            final_out = shifted;
        end
    end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
    import shf_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [AMT_W-1:0]  amt,
    input  shf_kind_e         kind,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stage [0:AMT_W];

    assign stage[0] = din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [DATA_W-1:0] moved;
        always_comb begin
            case (kind)
                K_LEFT:  moved = stage[k] << STEP;
                K_ARITH: moved = DATA_W'($signed(stage[k]) >>> STEP);
                default: moved = stage[k] >> STEP;
            endcase
        end
        assign stage[k+1] = amt[k] ? moved : stage[k];
    end

    assign dout = stage[AMT_W];

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32,
    localparam int AMT_W = $clog2(DATA_W),
    localparam int IMM_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op,
    input  logic [IMM_W-1:0]  shamt,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
    } unit_state_t;

    unit_state_t state_d, state_q;

    shf_op_e           op_e;
    logic [AMT_W-1:0]  amt;
    shf_kind_e         kind;
    logic              is_word;
    logic              is_valid;
    logic [DATA_W-1:0] core_in;
    logic [DATA_W-1:0] core_out;
    logic [DATA_W-1:0] shaped;

    assign op_e = shf_op_e'(op);

    shf_amt_sel #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_amt (
        .op       (op_e),
        .imm      (shamt),
        .amt_reg  (amt_reg),
        .amt      (amt),
        .kind     (kind),
        .is_word  (is_word),
        .is_valid (is_valid)
    );

    shf_word_adapt #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_word (
        .operand   (operand),
        .kind      (kind),
        .is_word   (is_word),
        .shifted   (core_out),
        .core_in   (core_in),
        .final_out (shaped)
    );

    shf_barrel #(.DATA_W(DATA_W)) u_core (
        .din  (core_in),
        .amt  (amt),
        .kind (kind),
        .dout (core_out)
    );

    always_comb begin
        state_d     = state_q;
        state_d.res = is_valid ? shaped : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result = state_q.res;

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op,
    input logic [4:0]        shamt,
    input logic [DATA_W-1:0] amt_reg,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] result
);

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> result == '0);

    // R2, R3, R4: word forms are sign-extended from bit 31 of their result
    assert_word_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op <= 4'd5) |=> result[DATA_W-1:WORD_W] == {(DATA_W-WORD_W){result[WORD_W-1]}});

    assert_wvar_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd3 && amt_reg[4:0] == 5'd0) |=>
        result == {{(DATA_W-WORD_W){$past(operand[WORD_W-1])}}, $past(operand[WORD_W-1:0])});

    assert_dimm_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd6 && shamt == 5'd0) |=> result == $past(operand));

    assert_dhi_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd12) |=> result[WORD_W-1:0] == '0);

    assert_dhi_logic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd13) |=> result[DATA_W-1:WORD_W] == '0);

    assert_dhi_arith_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd14) |=> result[DATA_W-1:WORD_W] == {(DATA_W-WORD_W){$past(operand[DATA_W-1])}});

    assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd15) |=> result == '0);

endmodule

bind shf_unit shf_unit_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .shamt   (shamt),
    .amt_reg (amt_reg),
    .operand (operand),
    .result  (result)
);

// File: tb/sim_shf_unit.sv
`timescale 1ns/1ps
module sim_shf_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [4:0]  shamt = 5'd0;
    logic [63:0] amt_reg = '0;
    logic [63:0] operand = '0;
    logic [63:0] result;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shf_unit u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .shamt   (shamt),
        .amt_reg (amt_reg),
        .operand (operand),
        .result  (result)
    );

    function automatic logic [63:0] sx32(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [63:0] expect_of(input logic [3:0] o, input logic [63:0] x,
                                              input logic [4:0] im, input logic [63:0] rg);
        logic [31:0] w;
        logic [5:0]  hi;
        w  = x[31:0];
        hi = 6'd32 + {1'b0, im};
        case (o)
            4'd0:  return sx32(w << im);
            4'd1:  return sx32(w >> im);
            4'd2:  return sx32($signed(w) >>> im);
            4'd3:  return sx32(w << rg[4:0]);
            4'd4:  return sx32(w >> rg[4:0]);
            4'd5:  return sx32($signed(w) >>> rg[4:0]);
            4'd6:  return x << im;
            4'd7:  return x >> im;
            4'd8:  return $signed(x) >>> im;
            4'd9:  return x << rg[5:0];
            4'd10: return x >> rg[5:0];
            4'd11: return $signed(x) >>> rg[5:0];
            4'd12: return x << hi;
            4'd13: return x >> hi;
            4'd14: return $signed(x) >>> hi;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0:                return "R2";
            4'd1:                return "R3";
            4'd2:                return "R4";
            4'd3, 4'd4, 4'd5:    return "R5";
            4'd6, 4'd7, 4'd8:    return "R6";
            4'd9, 4'd10, 4'd11:  return "R7";
            4'd12, 4'd13, 4'd14: return "R8";
            default:             return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s op=%0d actual=%h expected=%h", tag, op, got, exp);
        end
    endtask

    task automatic run(input logic [3:0] o, input logic [63:0] x,
                       input logic [4:0] im, input logic [63:0] rg);
        @(negedge clk);
        op = o; operand = x; shamt = im; amt_reg = rg;
        @(negedge clk);
        check(tag_of(o), result, expect_of(o, x, im, rg));
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check("R1", result, 64'd0);
        rst_n = 1'b1;
        op = 4'd7; operand = 64'hFFFF_FFFF_FFFF_FFFF; shamt = 5'd1;
        #1;
        check("R1", result, 64'd0);

        // directed corners
        run(4'd1, 64'h0000_0000_8000_0001, 5'd0, '0);         // R3: shift by zero still extends bit 31
        run(4'd2, 64'h1234_5678_8000_0000, 5'd31, '0);        // R4
        run(4'd0, 64'hFFFF_FFFF_0000_0001, 5'd31, '0);        // R2
        run(4'd4, 64'h0000_0000_F000_0000, 5'd4, 64'hFFFF_FFFF_FFFF_FFE4); // R5 upper bits ignored
        run(4'd10, 64'h8000_0000_0000_0000, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF); // R7 amount 63
        run(4'd14, 64'h8000_0000_0000_0000, 5'd31, '0);       // R8 amount 63
        run(4'd12, 64'h0000_0000_0000_0001, 5'd0, '0);        // R8 amount 32
        run(4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 5'd3, 64'd3);     // R9

        // R10: back-to-back operations each appear one edge later
        @(negedge clk);
        op = 4'd6; operand = 64'h0000_0000_0000_00F0; shamt = 5'd4; amt_reg = '0;
        @(negedge clk);
        check("R10", result, 64'h0000_0000_0000_0F00);
        op = 4'd7; shamt = 5'd4;
        @(negedge clk);
        check("R10", result, 64'h0000_0000_0000_000F);

        // random sweep over every code and all 64 amounts
        for (int o = 0; o < 16; o++) begin
            for (int a = 0; a < 64; a++) begin
                logic [63:0] x;
                logic [63:0] rg;
                logic [5:0]  a6;
                a6 = 6'(a);
                x  = {$urandom(), $urandom()};
                rg = {$urandom(), $urandom()};
                rg[5:0] = a6;
                run(4'(o), x, a6[4:0], rg);
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule